// File: doc/BRIEF.md
# I2C Target Byte Engine with Status Codes

This block is the target (slave) side of an I2C bus, run byte by byte by software through a small register bus. It watches the open-drain SCL and SDA lines and compares each address byte with a programmable 7-bit station address. When that address arrives, it acknowledges on the ninth clock. Data the controller writes is collected into a data register. Data the controller reads is shifted out of that same register, most significant bit first.

Every completed bus event raises one service flag and publishes an 8-bit status code that names the event. While a byte event waits for service, the block holds SCL low, so the controller cannot start the next byte until software has read or loaded the data and cleared the flag. A station-address bit also allows the all-zero general-call address to be accepted. Control bits are changed through two write ports: one sets the bits written as 1, the other clears them.

Top module: `i2c_target_core`

## Requirements
- R1: After reset the control register reads 0x00, the status reads 0xF8, `irq` is low and neither line is driven.
- R2: A write to offset 0 sets, and a write to offset 1 clears, the control bits written as 1. The control register reads enable at bit 6, flag at bit 3 and acknowledge at bit 2. Offset 2 holds the data byte, offset 3 the station address, and a read of offset 1 returns the status. Software cannot set the flag through offset 0.
- R3: With enable and acknowledge set, an address byte whose bits 7:1 equal station-address bits 7:1 and whose bit 0 is 0 is acknowledged (SDA low on the ninth clock). After the ninth clock the flag rises with status 0x60.
- R4: The same address with bit 0 equal to 1 gives status 0xA8. After the flag is cleared, the data register is shifted out MSB first.
- R5: When station-address bit 0 is 1, address byte 0x00 is acknowledged with status 0x70, and bytes that follow it give 0x90. When that bit is 0, address 0x00 gets no response.
- R6: A byte written by the controller after own-address selection is acknowledged and stored in the data register, with status 0x80.
- R7: After a byte the block has sent, the status is 0xB8 if the controller answered ACK with acknowledge set, 0xC0 if it answered NACK, and 0xC8 if it answered ACK with acknowledge cleared. Clearing the flag after 0xC0 or 0xC8 leaves the block unaddressed with SDA released.
- R8: A STOP or a repeated START seen while addressed sets the flag with status 0xA0 and does not hold SCL. After a repeated START, a new address is recognised.
- R9: For byte events, SCL is held low from the moment the flag rises until one cycle after software clears it.
- R10: With acknowledge cleared, the station address gets no ACK and no flag. A foreign address is ignored in the same way.
- R11: Whenever the flag is clear, the status reads 0xF8.
- R12: With enable cleared the block drives neither line and raises no flag.
- R13: A written byte that arrives while acknowledge is cleared is answered with NACK. The data register keeps its old value, no flag is raised, and the block becomes unaddressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| irq | output | 1 | Service flag |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest conditions to reach are the ones where software changes the acknowledge bit between bus events: the 0xC8 ending of a read, and the silent NACK of a written byte. They depend on the order in which the control bit changes, the flag is cleared and the bus master moves on. The bench drives a bit-level bus master with stretch-aware clock release from the same thread that services the flag, so every step lands in a fixed position relative to the stretched clock. Repeated-START handling is reached the same way. A per-clock monitor checks the idle status code and that the lines stay silent during transfers the block must ignore.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;

  localparam int CB_EN   = 6;
  localparam int CB_FLAG = 3;
  localparam int CB_ACK  = 2;

  localparam logic [BYTE_W-1:0] SC_SEL_WR  = 8'h60;
  localparam logic [BYTE_W-1:0] SC_SEL_GC  = 8'h70;
  localparam logic [BYTE_W-1:0] SC_RX_OWN  = 8'h80;
  localparam logic [BYTE_W-1:0] SC_RX_GC   = 8'h90;
  localparam logic [BYTE_W-1:0] SC_END     = 8'hA0;
  localparam logic [BYTE_W-1:0] SC_SEL_RD  = 8'hA8;
  localparam logic [BYTE_W-1:0] SC_TX_ACK  = 8'hB8;
  localparam logic [BYTE_W-1:0] SC_TX_NACK = 8'hC0;
  localparam logic [BYTE_W-1:0] SC_TX_LAST = 8'hC8;
  localparam logic [BYTE_W-1:0] SC_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_WAIT
  } eng_state_t;
endpackage

// File: rtl/i2ct_line_sense.sv
module i2ct_line_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_lvl;
      sda_p  <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign ev_rise  = scl_lvl & ~scl_p;
  assign ev_fall  = ~scl_lvl & scl_p;
  assign ev_start = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign ev_stop  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_we,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              flag,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rdata,
  output logic              en,
  output logic              ack_en,
  output logic [BYTE_W-1:0] own_addr,
  output logic [BYTE_W-1:0] data_q,
  output logic              flag_clr
);
  logic en_n, ack_n;
  logic [BYTE_W-1:0] data_n, own_n, ctrl_view;
  logic wr_set, wr_clr;

  assign wr_set   = we && (addr == 2'd0);
  assign wr_clr   = we && (addr == 2'd1);
  assign flag_clr = wr_clr && wdata[CB_FLAG];

  always_comb begin
    en_n   = en;
    ack_n  = ack_en;
    data_n = data_q;
    own_n  = own_addr;
    if (wr_set) begin
      en_n  = en | wdata[CB_EN];
      ack_n = ack_en | wdata[CB_ACK];
    end
    if (wr_clr) begin
      en_n  = en & ~wdata[CB_EN];
      ack_n = ack_en & ~wdata[CB_ACK];
    end
    if (rx_we)
      data_n = rx_byte;
    else if (we && addr == 2'd2)
      data_n = wdata;
    if (we && addr == 2'd3)
      own_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      ack_en   <= 1'b0;
      data_q   <= '0;
      own_addr <= '0;
    end else begin
      en       <= en_n;
      ack_en   <= ack_n;
      data_q   <= data_n;
      own_addr <= own_n;
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_EN]   = en;
    ctrl_view[CB_FLAG] = flag;
    ctrl_view[CB_ACK]  = ack_en;
    unique case (addr)
      2'd0:    rdata = ctrl_view;
      2'd1:    rdata = status;
      2'd2:    rdata = data_q;
      default: rdata = own_addr;
    endcase
  end

  // R13
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> ack_en);
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              flag_clr,
  input  logic              sda_lvl,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  output logic              flag,
  output logic [BYTE_W-1:0] status,
  output logic              rx_we,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  eng_state_t st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, code_q, code_n, set_code;
  logic gc_q, gc_n, rd_q, rd_n, fin_q, fin_n, mack_q, mack_n;
  logic flag_n, str_q, str_n, str_d_q, sdl_q, sdl_n;
  logic set_flag, set_str, addressed, hit_own, hit_gc;

  assign addressed = (st_q != ST_IDLE) && (st_q != ST_ADDR);
  assign hit_own   = sh_q[BYTE_W-1:1] == own_addr[BYTE_W-1:1];
  assign hit_gc    = (sh_q == '0) && own_addr[0];

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q;  sh_n = sh_q;
    gc_n = gc_q;  rd_n = rd_q;    fin_n = fin_q;  mack_n = mack_q;
    sdl_n = sdl_q;
    rx_we = 1'b0; set_flag = 1'b0; set_str = 1'b0; set_code = code_q;
    if (!en) begin
      st_n  = ST_IDLE;
      sdl_n = 1'b0;
    end else if (ev_start || ev_stop) begin
      if (addressed) begin
        set_flag = 1'b1;
        set_code = SC_END;
      end
      st_n  = ev_start ? ST_ADDR : ST_IDLE;
      cnt_n = '0;
      sdl_n = 1'b0;
      fin_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX: begin
          if (ev_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt_q + 1'b1;
          end else if (ev_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_ADDR && ack_en && (hit_own || hit_gc)) begin
              st_n  = ST_AACK;
              sdl_n = 1'b1;
              rd_n  = sh_q[0];
              gc_n  = !hit_own;
            end else if (st_q == ST_RX && ack_en) begin
              rx_we = 1'b1;
              st_n  = ST_RACK;
              sdl_n = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK, ST_RACK: begin
          if (ev_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (ev_fall && cnt_q == ACK_BIT) begin
            sdl_n    = 1'b0;
            set_flag = 1'b1;
            set_str  = 1'b1;
            fin_n    = 1'b0;
            st_n     = ST_WAIT;
            if (st_q == ST_RACK)  set_code = gc_q ? SC_RX_GC : SC_RX_OWN;
            else if (rd_q)        set_code = SC_SEL_RD;
            else                  set_code = gc_q ? SC_SEL_GC : SC_SEL_WR;
          end
        end
        ST_TX: begin
          if (ev_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (ev_fall) begin
            if (cnt_q == LAST_BIT) begin
              sdl_n = 1'b0;
              st_n  = ST_TACK;
            end else begin
              sh_n  = sh_q << 1;
              sdl_n = !sh_q[BYTE_W-2];
            end
          end
        end
        ST_TACK: begin
          if (ev_rise) begin
            cnt_n  = cnt_q + 1'b1;
            mack_n = !sda_lvl;
          end else if (ev_fall && cnt_q == ACK_BIT) begin
            set_flag = 1'b1;
            set_str  = 1'b1;
            set_code = !mack_q ? SC_TX_NACK : (!ack_en ? SC_TX_LAST : SC_TX_ACK);
            fin_n    = !mack_q || !ack_en;
            st_n     = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (flag_clr && flag) begin
            cnt_n = '0;
            if (fin_q) begin
              st_n = ST_IDLE;
            end else if (rd_q) begin
              sh_n  = tx_byte;
              sdl_n = !tx_byte[BYTE_W-1];
              st_n  = ST_TX;
            end else begin
              st_n = ST_RX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    flag_n = flag;
    str_n  = str_q;
    code_n = code_q;
    if (set_flag) begin
      flag_n = 1'b1;
      str_n  = set_str;
      code_n = set_code;
    end else if (flag_clr) begin
      flag_n = 1'b0;
      str_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  code_q <= SC_NONE;
      gc_q <= 1'b0;  rd_q <= 1'b0;  fin_q <= 1'b0;  mack_q <= 1'b0;
      flag <= 1'b0;  str_q <= 1'b0;  str_d_q <= 1'b0;  sdl_q <= 1'b0;
    end else begin
      st_q <= st_n;  cnt_q <= cnt_n;  sh_q <= sh_n;  code_q <= code_n;
      gc_q <= gc_n;  rd_q <= rd_n;  fin_q <= fin_n;  mack_q <= mack_n;
      flag <= flag_n;  str_q <= str_n;  str_d_q <= str_q;  sdl_q <= sdl_n;
    end
  end

  assign status  = flag ? code_q : SC_NONE;
  assign rx_byte = sh_q;
  assign scl_oe  = str_q | str_d_q;
  assign sda_oe  = sdl_q;

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && flag) |-> scl_oe);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);
  // R12
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == ST_IDLE));
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;
  logic en, ack_en, flag_clr, rx_we;
  logic [BYTE_W-1:0] own_addr, data_q, status, rx_byte;

  i2ct_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2ct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rx_we(rx_we), .rx_byte(rx_byte), .flag(irq), .status(status),
    .rdata(bus_rdata), .en(en), .ack_en(ack_en), .own_addr(own_addr),
    .data_q(data_q), .flag_clr(flag_clr)
  );

  i2ct_engine u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .ack_en(ack_en), .own_addr(own_addr),
    .tx_byte(data_q), .flag_clr(flag_clr), .sda_lvl(sda_lvl),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .flag(irq), .status(status), .rx_we(rx_we), .rx_byte(rx_byte),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // R2
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_we && bus_addr == 2'd1 && bus_wdata[CB_FLAG]));
endmodule

// File: tb/i2c_target_core_test.sv
`timescale 1ns/100ps
module i2c_target_core_test;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd1;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, scl_oe, sda_oe;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line;

  int checks = 0, fails = 0;
  bit done = 1'b0, quiet = 1'b0;
  string quiet_tag = "";
  int exp_data = 0;

  always #2.5 clk = ~clk;
  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_target_core uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // per-clock reference: idle status code and silence on ignored transfers
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (!irq && !bus_we && bus_addr == 2'd1) chk("R11 idle status", bus_rdata, 8'hF8);
      if (quiet) chk(quiet_tag, {5'd0, irq, sda_oe, scl_oe}, 8'h00);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a;
    @(posedge clk); #1 v = bus_rdata; bus_addr = 2'd1;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b1; hold(HALF); m_scl_low = 1'b1; hold(HALF);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; hold(HALF); scl_up(); hold(HALF); m_sda_low = 1'b0; hold(HALF);
  endtask

  task automatic m_rstart();
    m_sda_low = 1'b0; hold(HALF); scl_up(); hold(HALF);
    m_sda_low = 1'b1; hold(HALF); m_scl_low = 1'b1; hold(HALF);
  endtask

  task automatic m_bit_w(input logic b);
    m_sda_low = !b; hold(HALF); scl_up(); hold(HALF); m_scl_low = 1'b1;
  endtask

  task automatic m_bit_r(output logic b);
    m_sda_low = 1'b0; hold(HALF); scl_up(); hold(HALF / 2);
    b = sda_line; hold(HALF / 2); m_scl_low = 1'b1;
  endtask

  task automatic m_byte_w(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
    m_bit_r(b);
    acked = !b;
  endtask

  task automatic m_byte_r(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit_r(d[i]);
    m_bit_w(!give_ack);
    m_sda_low = 1'b0;
  endtask

  task automatic svc(input logic [7:0] code, input string tag);
    logic [7:0] v;
    for (int i = 0; i < 80 && !irq; i++) @(negedge clk);
    chk({tag, " flag"}, {7'd0, irq}, 8'h01);
    rd(2'd1, v);
    chk({tag, " status"}, v, code);
    if (code != 8'hA0) begin
      hold(4);
      chk("R9 scl held while flag pending", {7'd0, scl_line}, 8'h00);
    end else begin
      chk("R8 no hold on end event", {7'd0, scl_oe}, 8'h00);
    end
  endtask

  task automatic clr(input logic stretched);
    wr(2'd1, 8'h08);
    if (stretched) chk("R9 hold lasts one cycle past clear", {7'd0, scl_oe}, 8'h01);
    @(negedge clk);
    chk("R9 scl released after clear", {7'd0, scl_oe}, 8'h00);
    chk("R11 status after clear", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    logic a;
    hold(5); rst_n = 1'b1; hold(2);

    // R1 reset state
    rd(2'd0, v); chk("R1 control", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'hF8);
    chk("R1 lines", {5'd0, irq, sda_oe, scl_oe}, 8'h00);

    // R2 set/clear access
    wr(2'd0, 8'h44); rd(2'd0, v); chk("R2 set bits", v, 8'h44);
    wr(2'd0, 8'h08); rd(2'd0, v); chk("R2 flag not settable", v, 8'h44);
    wr(2'd1, 8'h04); rd(2'd0, v); chk("R2 clear bit", v, 8'h40);
    wr(2'd0, 8'h04);
    wr(2'd3, 8'h5A); rd(2'd3, v); chk("R2 own address", v, 8'h5A);

    // R3 R6 R8 write transfer
    m_start(); m_byte_w(8'h5A, a); chk("R3 address ack", {7'd0, a}, 8'h01);
    svc(8'h60, "R3"); clr(1'b1);
    m_byte_w(8'hC3, a); chk("R6 data ack", {7'd0, a}, 8'h01);
    svc(8'h80, "R6"); exp_data = 8'hC3;
    rd(2'd2, v); chk("R6 data stored", v, exp_data[7:0]);
    clr(1'b1);
    m_stop(); svc(8'hA0, "R8 stop"); clr(1'b0);

    // R4 R7 read transfer ending 0xC8
    m_start(); m_byte_w(8'h5B, a); chk("R4 read address ack", {7'd0, a}, 8'h01);
    svc(8'hA8, "R4"); wr(2'd2, 8'h96); clr(1'b1);
    m_byte_r(1'b1, v); chk("R4 byte shifted out", v, 8'h96);
    svc(8'hB8, "R7 acked"); wr(2'd1, 8'h04); wr(2'd2, 8'h3C); clr(1'b1);
    m_byte_r(1'b1, v); chk("R4 second byte", v, 8'h3C);
    svc(8'hC8, "R7 last"); clr(1'b1);
    chk("R7 sda released", {7'd0, sda_oe}, 8'h00);
    quiet = 1'b1; quiet_tag = "R7 unaddressed after C8";
    m_stop(); quiet = 1'b0;
    wr(2'd0, 8'h04);

    // R7 read transfer ending with NACK
    m_start(); m_byte_w(8'h5B, a);
    svc(8'hA8, "R7 nack select"); wr(2'd2, 8'h81); exp_data = 8'h81; clr(1'b1);
    m_byte_r(1'b0, v); chk("R7 nack byte", v, 8'h81);
    svc(8'hC0, "R7 nack"); clr(1'b1);
    quiet = 1'b1; quiet_tag = "R7 unaddressed after C0";
    m_stop(); quiet = 1'b0;

    // R5 R8 general call and repeated start
    wr(2'd3, 8'h5B);
    m_start(); m_byte_w(8'h00, a); chk("R5 general call ack", {7'd0, a}, 8'h01);
    svc(8'h70, "R5 select"); clr(1'b1);
    m_byte_w(8'h11, a); chk("R5 gc data ack", {7'd0, a}, 8'h01);
    svc(8'h90, "R5 data"); exp_data = 8'h11; clr(1'b1);
    m_rstart(); svc(8'hA0, "R8 repeated start"); clr(1'b0);
    m_byte_w(8'h5A, a); chk("R8 new address ack", {7'd0, a}, 8'h01);
    svc(8'h60, "R8 reselect"); clr(1'b1);
    m_stop(); svc(8'hA0, "R8 final stop"); clr(1'b0);

    // R5 general call disabled
    wr(2'd3, 8'h5A);
    quiet = 1'b1; quiet_tag = "R5 gc disabled";
    m_start(); m_byte_w(8'h00, a); chk("R5 gc nack", {7'd0, a}, 8'h00);
    m_stop(); quiet = 1'b0;

    // R10 foreign address, then acknowledge cleared
    quiet = 1'b1; quiet_tag = "R10 foreign address";
    m_start(); m_byte_w(8'h20, a); chk("R10 foreign nack", {7'd0, a}, 8'h00);
    m_stop(); quiet = 1'b0;
    wr(2'd1, 8'h04);
    quiet = 1'b1; quiet_tag = "R10 ack bit cleared";
    m_start(); m_byte_w(8'h5A, a); chk("R10 own nack", {7'd0, a}, 8'h00);
    m_stop(); quiet = 1'b0;
    wr(2'd0, 8'h04);

    // R13 written byte with acknowledge cleared
    m_start(); m_byte_w(8'h5A, a);
    svc(8'h60, "R13 select"); wr(2'd1, 8'h04); clr(1'b1);
    quiet = 1'b1; quiet_tag = "R13 silent nack";
    m_byte_w(8'h77, a); chk("R13 byte nacked", {7'd0, a}, 8'h00);
    rd(2'd2, v); chk("R13 data kept", v, exp_data[7:0]);
    m_stop(); quiet = 1'b0;
    wr(2'd0, 8'h04);

    // R12 enable cleared
    wr(2'd1, 8'h40); rd(2'd0, v); chk("R12 control", v, 8'h04);
    quiet = 1'b1; quiet_tag = "R12 disabled";
    m_start(); m_byte_w(8'h5A, a); chk("R12 nack", {7'd0, a}, 8'h00);
    m_stop(); quiet = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule